// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block turns a three-level pulse-width input into a drive command for a synchronous buck gate-drive sequencer. Two comparator flags come in asynchronously. One says the pin is above the upper logic threshold and the other says it is below the lower one. The block passes both flags through a synchroniser and rejects chatter by requiring each level to persist. It then produces a two-bit command: switch the high side on, switch the low side on, or switch both off.

A pin parked between the two thresholds is the signal a multi-phase controller uses to shed a phase. An undriven pin also floats to this middle region. The block acts on it only after the pin has stayed there without a break for a hold-off time, which defaults to 250 ns (50 cycles at 200 MHz). Before that time runs out, a pin crossing the middle region on an ordinary edge leaves the last valid command in place. Leaving the off state needs no wait in either direction: the next valid level is obeyed at once. The analog comparators are outside the block.

Top module: `tri_pwm_decoder`

## Requirements
- R1: While reset is asserted and after it is released with the pin in the middle region, `cmd` is 2'b10 (both off) and `tri_active` is 1.
- R2: The command encoding is 2'b01 = high side on, 2'b00 = low side on and 2'b10 = both off. The value 2'b11 never appears, and `tri_active` is 1 exactly when `cmd` is 2'b10.
- R3: The flag pair maps to a level as follows. Only `above_hi` set gives high. Only `below_lo` set gives low. Neither flag set gives middle, which is also what a floating pin produces. Both flags set is treated as middle.
- R4: Each flag passes a two-stage synchroniser. A level is accepted only after it has been seen for two consecutive cycles, so a one-cycle pulse never changes `cmd`.
- R5: Suppose a high or low level is applied before rising edge 1 and held. Then `cmd` shows it after edge 5 and not after edge 4.
- R6: While the accepted level is middle and the hold-off has not run out, `cmd` keeps the last valid high or low command.
- R7: A steady middle level held for HOLD_CYCLES cycles (default 50) gives `cmd` = 2'b10. If the level is applied before edge 1 after a high or low command, `cmd` turns off after edge 4+HOLD_CYCLES and not after edge 3+HOLD_CYCLES.
- R8: Leaving the off state is immediate. A high or low level reaches `cmd` with the same five-edge latency as in R5, with no added hold-off.
- R9: Any cycle in which the synchronised pin is outside the middle region restarts the hold-off count, even when the excursion is too short to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_hi | input | 1 | Asynchronous flag: pin above the upper threshold |
| below_lo | input | 1 | Asynchronous flag: pin below the lower threshold |
| cmd | output | 2 | Drive command: 01 high side, 00 low side, 10 both off |
| tri_active | output | 1 | Set while the both-off command is in force |

## Verification
The assertions assume that the flags carry no meaning faster than the synchroniser can resolve. They also assume that a both-flags-set pair only ever stands for a middle-region pin. Given those assumptions, they relate the accepted level and the hold-off expiry to the command one cycle later. The stimulus changes the flags only between clock edges. It holds each random level for a random span that ranges from single-cycle chatter up to beyond the hold-off. It mixes in both-flags-set spans and single-cycle excursions out of the middle region, so that the restart path is exercised.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_MID  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_OFF  = 2'b10
  } cmd_e;

  // Map comparator flags to a level; contradictory pair counts as middle.
  function automatic lvl_e classify(input logic above, input logic below);
    if (above && !below) return LVL_HIGH;
    if (below && !above) return LVL_LOW;
    return LVL_MID;
  endfunction

  // Hold-off in clock cycles, rounded up.
  function automatic int hold_cycles(input int hold_ns, input int clk_ps);
    return (hold_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tri_pwm_sync.sv
module tri_pwm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/tri_pwm_filter.sv
module tri_pwm_filter
  import tri_pwm_pkg::*;
#(
  parameter int STABLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_e lvl_in,
  output lvl_e lvl_acc
);
  localparam int CW = cnt_width(STABLE);

  lvl_e          cand;
  logic [CW-1:0] run;
  logic          same;
  logic          ripe;

  assign same = (lvl_in == cand);
  assign ripe = same && (run >= CW'(STABLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand    <= LVL_MID;
      run     <= '0;
      lvl_acc <= LVL_MID;
    end else begin
      if (!same) begin
        cand <= lvl_in;
        run  <= CW'(1);
      end else if (run < CW'(STABLE - 1)) begin
        run <= run + CW'(1);
      end
      if (ripe) lvl_acc <= cand;
    end
  end
endmodule

// File: rtl/tri_pwm_holdoff.sv
module tri_pwm_holdoff #(
  parameter int HOLD = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_mid,
  input  logic raw_mid,
  output logic hold_done
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [HW-1:0] cnt;
  logic          arm;
  logic          at_end;

  assign arm       = acc_mid && raw_mid;
  assign at_end    = (cnt == HW'(HOLD - 1));
  assign hold_done = arm && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!arm)    cnt <= '0;
    else if (!at_end) cnt <= cnt + HW'(1);
  end
endmodule

// File: rtl/tri_pwm_decoder.sv
module tri_pwm_decoder
  import tri_pwm_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int HOLD_NS     = 250,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_hi,
  input  logic       below_lo,
  output logic [1:0] cmd,
  output logic       tri_active
);
  localparam int HOLD_CYCLES = hold_cycles(HOLD_NS, CLK_PS);

  logic [1:0] flags_s;
  lvl_e       lvl_raw;
  lvl_e       lvl_acc;
  logic       hold_done;
  cmd_e       cmd_q;
  logic       tri_q;

  tri_pwm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({above_hi, below_lo}),
    .d_sync(flags_s)
  );

  assign lvl_raw = classify(flags_s[1], flags_s[0]);

  tri_pwm_filter #(.STABLE(STABLE)) u_filt (
    .clk(clk), .rst_n(rst_n),
    .lvl_in(lvl_raw), .lvl_acc(lvl_acc)
  );

  tri_pwm_holdoff #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .acc_mid(lvl_acc == LVL_MID),
    .raw_mid(lvl_raw == LVL_MID),
    .hold_done(hold_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_OFF;
      tri_q <= 1'b1;
    end else begin
      unique case (lvl_acc)
        LVL_HIGH: begin cmd_q <= CMD_HIGH; tri_q <= 1'b0; end
        LVL_LOW:  begin cmd_q <= CMD_LOW;  tri_q <= 1'b0; end
        default: begin
          if (hold_done) begin
            cmd_q <= CMD_OFF;
            tri_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign cmd        = cmd_q;
  assign tri_active = tri_q;
endmodule

// File: rtl/tri_pwm_decoder_chk.sv
module tri_pwm_decoder_chk
  import tri_pwm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input lvl_e       lvl_raw,
  input lvl_e       lvl_acc,
  input logic       hold_done,
  input logic [1:0] cmd,
  input logic       tri_active
);
  // R2
  enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 2'b11) && (tri_active == (cmd == 2'b10)));

  // R5
  follow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_acc == LVL_HIGH) |=> (cmd == 2'b01));

  // R8
  follow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_acc == LVL_LOW) |=> (cmd == 2'b00));

  // R6
  mid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_acc == LVL_MID && !hold_done) |=> $stable(cmd));

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> (cmd == 2'b10));

  // R9
  hold_only_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |-> (lvl_acc == LVL_MID && lvl_raw == LVL_MID));

  // R4
  accept_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_acc) |-> ($past(lvl_raw) == lvl_acc));
endmodule

bind tri_pwm_decoder tri_pwm_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_raw(lvl_raw), .lvl_acc(lvl_acc),
  .hold_done(hold_done), .cmd(cmd), .tri_active(tri_active)
);

// File: tb/tri_pwm_decoder_tb.sv
`timescale 1ns/1ps
module tri_pwm_decoder_tb;
  localparam int HOLD   = 250 * 1000 / 5000;
  localparam int STABLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_hi = 1'b0;
  logic below_lo = 1'b0;
  logic [1:0] cmd;
  logic tri_active;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tri_pwm_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .above_hi(above_hi), .below_lo(below_lo),
    .cmd(cmd), .tri_active(tri_active)
  );

  // bench level codes: 0 low side, 1 high side, 2 middle
  function automatic int pin_class(input logic a, input logic b);
    if (a == b) return 2;
    return a ? 1 : 0;
  endfunction

  function automatic int cmd_code(input int lvl);
    return (lvl == 1) ? 1 : (lvl == 0) ? 0 : 2;
  endfunction

  int m_s1, m_s2, m_cand, m_run, m_acc, m_mid, m_cmd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 2; m_s2 <= 2; m_cand <= 2; m_run <= 0;
      m_acc <= 2; m_mid <= 0; m_cmd <= 2;
    end else begin
      m_s1 <= pin_class(above_hi, below_lo);
      m_s2 <= m_s1;
      if (m_s2 != m_cand) begin m_cand <= m_s2; m_run <= 1; end
      else if (m_run < STABLE) m_run <= m_run + 1;
      if (m_s2 == m_cand && m_run >= STABLE - 1) m_acc <= m_cand;
      if (m_acc == 2 && m_s2 == 2) m_mid <= (m_mid < HOLD) ? m_mid + 1 : m_mid;
      else m_mid <= 0;
      if (m_acc != 2) m_cmd <= cmd_code(m_acc);
      else if (m_s2 == 2 && m_mid >= HOLD - 1) m_cmd <= 2;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int lvl, input bit both);
    above_hi = (lvl == 1) || (lvl == 2 && both);
    below_lo = (lvl == 0) || (lvl == 2 && both);
  endtask

  task automatic check_model(input string req);
    check(req, int'(cmd), m_cmd);
    check("R2", int'(tri_active), (m_cmd == 2) ? 1 : 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    @(negedge clk);
    check("R1", int'(cmd), 2);
    check("R1", int'(tri_active), 1);
    rst_n = 1'b1;
    tick(3);
    check("R1", int'(cmd), 2);

    // R5: high from off
    drive(1, 0);
    tick(4); check("R5", int'(cmd), 2);
    tick(1); check("R5", int'(cmd), 1);
    check("R2", int'(tri_active), 0);

    // R6 / R7: floating pin
    drive(2, 0);
    tick(3 + HOLD); check("R6", int'(cmd), 1);
    tick(1); check("R7", int'(cmd), 2);
    check("R2", int'(tri_active), 1);

    // R8: off to low, no extra wait
    drive(0, 0);
    tick(4); check("R8", int'(cmd), 2);
    tick(1); check("R8", int'(cmd), 0);

    // R3: both flags set behaves as middle
    drive(2, 1);
    tick(3 + HOLD); check("R3", int'(cmd), 0);
    tick(1); check("R3", int'(cmd), 2);

    // R4: one-cycle high pulse from off is ignored
    drive(1, 0); tick(1); drive(2, 0);
    tick(20); check("R4", int'(cmd), 2);

    // R9: one-cycle excursion restarts the hold-off
    drive(0, 0); tick(10); check("R9", int'(cmd), 0);
    drive(2, 0); tick(20);
    drive(1, 0); tick(1);
    drive(2, 0);
    tick(51); check("R9", int'(cmd), 0);
    tick(1);  check("R9", int'(cmd), 2);
    check_model("R9");

    // random segments checked every cycle against the bench model
    for (int s = 0; s < 160; s++) begin
      int lvl, len;
      bit both;
      lvl  = $urandom_range(0, 2);
      both = ($urandom_range(0, 4) == 0);
      len  = ($urandom_range(0, 3) == 0) ? 1 : $urandom_range(1, HOLD + 20);
      drive(lvl, both);
      for (int c = 0; c < len; c++) begin
        tick(1);
        check_model("R5");
      end
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule